// File: doc/BRIEF.md
# UART Transmitter with Watermark FIFO

This block is the transmit half of an asynchronous serial port. Software writes bytes into a small transmit FIFO through a byte-wide register port. A shifter takes one byte at a time from the FIFO and sends it as a serial frame on the TX line. Every bit of the frame lasts a fixed number of oversample ticks.

The frame format is set by a control register:
- eight data bits with no parity;
- seven data bits followed by a parity bit, in the same ten-bit frame;
- a nine-bit frame, whose ninth bit is either parity or a constant mark.

The block has three status outputs:
- A request output tells the host that there is room to refill. It is high while the FIFO count is at or below a programmable watermark.
- A completion output is high only when the FIFO is empty and the shifter has finished.
- An overflow output is sticky. It is set by a write that the FIFO had to drop.

The host can also flush the FIFO, hold the line in break, and read back:
- the FIFO count;
- the FIFO status;
- a parameter register that encodes the FIFO depth.

Register map (3-bit address):
- 0: data, write only. A write pushes the byte.
- 1: control. Bit 0 is enable, bit 1 is break, bit 2 is parity enable, bit 3 is odd parity, bit 4 is the nine-bit frame.
- 2: watermark.
- 3: FIFO command, write only. Bit 7 flushes the FIFO.
- 4: FIFO status. Bit 7 is empty, bit 6 is complete, bit 1 is overflow. Writing a one to bit 1 clears overflow.
- 5: parameter register.
- 6: count.

All other read addresses return zero.

Top module: `utx_wm`

## Requirements
- R1: After reset the line is high (idle), the count reads 0, `tx_done` and `tx_req` are 1, `tx_ovf` is 0, and the watermark register (address 2) reads 2.
- R2: Address 5 returns log2(DEPTH)-1 in bits 6:4, so that DEPTH = 2^(field+1), and zeros elsewhere. With DEPTH=8 it reads 0x20.
- R3: Address 6 returns the number of bytes held in the FIFO. Each accepted write to address 0 raises it by one, and the count never exceeds DEPTH.
- R4: `tx_req` is 1 exactly when the FIFO count is less than or equal to the watermark value.
- R5: A write to address 0 while the FIFO holds DEPTH bytes is dropped and leaves the count unchanged. It sets `tx_ovf` and status bit 1. Only a write with bit 1 set to address 4 clears them.
- R6: A write to address 3 with bit 7 set empties the FIFO in one cycle. A write there with bit 7 clear changes nothing.
- R7: With control bits 4 and 2 clear, a frame is sent in this order:
  - a start bit of 0;
  - data bits 0 to 7, least significant first;
  - a stop bit of 1.

  Each bit lasts OVS ticks, and the line is 1 between frames.
- R8: With bit 2 set and bit 4 clear, the frame carries data bits 0 to 6 and then a parity bit. With bit 3 clear the parity is even (the parity bit is the XOR of those data bits). With bit 3 set the parity is odd.
- R9: With bit 4 set, the frame carries eight data bits and then a ninth bit before the stop bit. The ninth bit is the parity of all eight data bits, with the type chosen by bit 3, when bit 2 is set. It is 1 when bit 2 is clear.
- R10: `tx_done` and status bit 6 are 1 only when the FIFO is empty and no frame is being shifted. They stay 0 while the last frame is still on the line.
- R11: While control bit 1 is set, the line is held at 0, no new frame starts, and the FIFO keeps its bytes. After the bit is cleared, the held bytes are sent normally.
- R12: Frames start only while control bit 0 is set, and bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tick | input | 1 | Oversample tick, one clock wide |
| txd | output | 1 | Serial transmit line |
| tx_req | output | 1 | FIFO count at or below watermark |
| tx_done | output | 1 | FIFO empty and shifter idle |
| tx_ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume the following about the block's inputs:
- DEPTH is a power of two.
- At most one register write occurs per cycle, so a flush, a push and an overflow clear never coincide.
- `wr_addr` and `wr_data` are known whenever `wr_en` is high.

The bench changes the frame-format bits only while `tx_done` is high. This way no frame mixes two formats. It keeps the tick high on every cycle, so that each bit lasts exactly OVS clocks. Its serial receiver samples each bit in the middle of its OVS window, counted from the first low level it sees.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_WMARK = 3'd2;
  localparam logic [2:0] A_FCMD  = 3'd3;
  localparam logic [2:0] A_FSTAT = 3'd4;
  localparam logic [2:0] A_PARAM = 3'd5;
  localparam logic [2:0] A_COUNT = 3'd6;

  localparam int FRAME_W = 11;

  typedef struct packed {
    logic nine;
    logic odd;
    logic par_en;
    logic brk;
    logic en;
  } utx_ctrl_t;

  // Frame bits, least significant bit sent first; unused upper bits are 1.
  function automatic logic [FRAME_W-1:0] utx_frame(input logic [7:0] d, input utx_ctrl_t c);
    logic p7;
    logic p8;
    p7 = (^d[6:0]) ^ c.odd;
    p8 = (^d) ^ c.odd;
    if (c.nine)
      utx_frame = {1'b1, (c.par_en ? p8 : 1'b1), d, 1'b0};
    else
      utx_frame = {2'b11, (c.par_en ? {p7, d[6:0]} : d), 1'b0};
  endfunction

  function automatic logic [3:0] utx_len(input utx_ctrl_t c);
    return c.nine ? 4'd11 : 4'd10;
  endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] PONE = 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PONE;
      if (pop)  rp <= rp + PONE;
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign count = cnt;
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [3:0]         len,
  input  logic               brk,
  output logic               busy,
  output logic               txd
);

  localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
  localparam logic [TW-1:0] TONE  = 1;

  logic [TW-1:0]      tcnt;
  logic [3:0]         bidx;
  logic [3:0]         blen;
  logic [FRAME_W-1:0] sr;
  logic               bit_end;

  assign bit_end = busy && tick && (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
      bidx <= '0;
      blen <= '0;
      sr   <= '1;
    end else if (load) begin
      busy <= 1'b1;
      tcnt <= '0;
      bidx <= '0;
      blen <= len;
      sr   <= frame;
    end else if (busy && tick) begin
      if (bit_end) begin
        tcnt <= '0;
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        if (bidx == blen - 4'd1) busy <= 1'b0;
        else                     bidx <= bidx + 4'd1;
      end else begin
        tcnt <= tcnt + TONE;
      end
    end
  end

  assign txd = brk ? 1'b0 : (busy ? sr[0] : 1'b1);

endmodule

// File: rtl/utx_wm.sv
module utx_wm
  import utx_pkg::*;
#(
  parameter int         DEPTH    = 8,
  parameter int         OVS      = 16,
  parameter logic [7:0] WM_RESET = 8'd2,
  localparam int        CW       = $clog2(DEPTH) + 1,
  localparam logic [2:0] PCODE   = 3'($clog2(DEPTH) - 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       tick,
  output logic       txd,
  output logic       tx_req,
  output logic       tx_done,
  output logic       tx_ovf
);

  utx_ctrl_t     ctrl_q;
  logic [7:0]    wmark_q;
  logic          ovf_q;

  logic [CW-1:0] fifo_count;
  logic [7:0]    count_b;
  logic          fifo_full;
  logic          fifo_empty;
  logic [7:0]    head;
  logic          sh_busy;

  // named internal events
  logic data_wr;
  logic push_ok;
  logic push_drop;
  logic flush_evt;
  logic ovf_clr;
  logic load_evt;

  assign data_wr   = wr_en && (wr_addr == A_DATA);
  assign push_ok   = data_wr && !fifo_full;
  assign push_drop = data_wr && fifo_full;
  assign flush_evt = wr_en && (wr_addr == A_FCMD) && wr_data[7];
  assign ovf_clr   = wr_en && (wr_addr == A_FSTAT) && wr_data[1];
  assign load_evt  = ctrl_q.en && !ctrl_q.brk && !sh_busy && !fifo_empty && !flush_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      wmark_q <= WM_RESET;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == A_CTRL))  ctrl_q  <= utx_ctrl_t'(wr_data[4:0]);
      if (wr_en && (wr_addr == A_WMARK)) wmark_q <= wr_data;
      if (push_drop)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  utx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .wdata (wr_data),
    .pop   (load_evt),
    .flush (flush_evt),
    .rdata (head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  utx_shifter #(.OVS(OVS)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .load  (load_evt),
    .frame (utx_frame(head, ctrl_q)),
    .len   (utx_len(ctrl_q)),
    .brk   (ctrl_q.brk),
    .busy  (sh_busy),
    .txd   (txd)
  );

  assign count_b = 8'(fifo_count);
  assign tx_req  = (count_b <= wmark_q);
  assign tx_done = fifo_empty && !sh_busy;
  assign tx_ovf  = ovf_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {3'b000, ctrl_q};
      A_WMARK: rd_data = wmark_q;
      A_FSTAT: rd_data = {fifo_empty, tx_done, 4'b0000, ovf_q, 1'b0};
      A_PARAM: rd_data = {1'b0, PCODE, 4'b0000};
      A_COUNT: rd_data = count_b;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/utx_wm_chk.sv
module utx_wm_chk #(
  parameter int  DEPTH = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          en,
  input logic          brk,
  input logic          flush,
  input logic          push_drop,
  input logic          load,
  input logic          tx_ovf,
  input logic          tx_done,
  input logic          txd
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop && !load |=> $stable(count)); // R5

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> tx_ovf); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !brk |-> txd); // R7

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> count == '0); // R10

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd); // R11

  AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    brk && !busy |=> !busy); // R11

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en) && $past(count) != '0); // R12

endmodule

bind utx_wm utx_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count     (fifo_count),
  .busy      (sh_busy),
  .en        (ctrl_q.en),
  .brk       (ctrl_q.brk),
  .flush     (flush_evt),
  .push_drop (push_drop),
  .load      (load_evt),
  .tx_ovf    (tx_ovf),
  .tx_done   (tx_done),
  .txd       (txd)
);

// File: tb/utx_wm_test.sv
`timescale 1ns/1ps
module utx_wm_test;

  localparam int DEPTH = 8;
  localparam int OVS   = 16;
  localparam int NVEC  = 7;
  // {control byte, data byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0155, 16'h01C3, 16'h0535, 16'h0D35, 16'h1196, 16'h1596, 16'h1D01
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic       tick = 1'b1;
  logic [7:0] rd_data;
  logic       txd, tx_req, tx_done, tx_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  utx_wm #(.DEPTH(DEPTH), .OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .txd(txd),
    .tx_req(tx_req), .tx_done(tx_done), .tx_ovf(tx_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic void exp_frame(input logic [7:0] c, input logic [7:0] d,
                                    output logic [10:0] f, output int n);
    bit p;
    f = '1;
    f[0] = 1'b0;
    p = c[3];
    if (c[4]) begin
      n = 11;
      for (int i = 0; i < 8; i++) begin f[1+i] = d[i]; p ^= d[i]; end
      f[9] = c[2] ? p : 1'b1;
    end else begin
      n = 10;
      if (c[2]) begin
        for (int i = 0; i < 7; i++) begin f[1+i] = d[i]; p ^= d[i]; end
        f[8] = p;
      end else begin
        for (int i = 0; i < 8; i++) f[1+i] = d[i];
      end
    end
    f[n-1] = 1'b1;
  endfunction

  task automatic rx_frame(input int n, output logic [10:0] got, output bit ok);
    int waited;
    waited = 0;
    got = '1;
    ok = 1'b0;
    while (txd !== 1'b0 && waited < 4000) begin @(negedge clk); waited++; end
    if (txd === 1'b0) begin
      repeat (OVS/2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        got[i] = txd;
        if (i < n - 1) repeat (OVS) @(negedge clk);
      end
      ok = 1'b1;
    end
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (tx_done !== 1'b1 && k < 2000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [10:0] got;
    logic [10:0] ef;
    int          n;
    bit          ok;
    int          lowbad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 tx_ovf", tx_ovf, 0);
    rd(3'd6, r); chk("R1 count", r, 0);
    rd(3'd2, r); chk("R1 wmark", r, 2);
    // R2 depth code
    rd(3'd5, r); chk("R2 param", r, 8'h20);

    // R3 R4 R12 fill with transmitter disabled
    wr(3'd0, 8'hA5); wr(3'd0, 8'h3C); wr(3'd0, 8'h0F);
    rd(3'd6, r); chk("R3 count after 3", r, 3);
    chk("R4 req count3 wm2", tx_req, 0);
    chk("R10 done with bytes", tx_done, 0);
    lowbad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1) lowbad++; end
    chk("R12 idle while disabled", lowbad, 0);
    wr(3'd2, 8'd3);
    chk("R4 req count3 wm3", tx_req, 1);
    wr(3'd2, 8'd2);
    chk("R4 req count3 wm2 again", tx_req, 0);

    // R5 overflow
    for (int i = 0; i < 5; i++) wr(3'd0, 8'h10 + 8'(i));
    rd(3'd6, r); chk("R3 count full", r, 8);
    chk("R5 ovf before drop", tx_ovf, 0);
    wr(3'd0, 8'hEE);
    rd(3'd6, r); chk("R5 count after drop", r, 8);
    chk("R5 ovf set", tx_ovf, 1);
    rd(3'd4, r); chk("R5 status bit1", r[1], 1);
    wr(3'd4, 8'h00);
    chk("R5 ovf kept on zero write", tx_ovf, 1);
    wr(3'd4, 8'h02);
    chk("R5 ovf cleared", tx_ovf, 0);

    // R6 flush
    wr(3'd3, 8'h7F);
    rd(3'd6, r); chk("R6 no flush without bit7", r, 8);
    wr(3'd3, 8'h80);
    rd(3'd6, r); chk("R6 count after flush", r, 0);
    rd(3'd4, r); chk("R6 status empty", r[7], 1);
    chk("R10 done after flush", tx_done, 1);

    // R12 order, R10 done timing
    wr(3'd0, 8'hA5); wr(3'd0, 8'h3C);
    wr(3'd1, 8'h01);
    exp_frame(8'h01, 8'hA5, ef, n);
    rx_frame(n, got, ok);
    chk("R12 first frame", {ok, got}, {1'b1, ef});
    chk("R10 done with byte queued", tx_done, 0);
    exp_frame(8'h01, 8'h3C, ef, n);
    rx_frame(n, got, ok);
    chk("R12 second frame", {ok, got}, {1'b1, ef});
    chk("R10 done while stop bit on line", tx_done, 0);
    rd(3'd4, r); chk("R10 status bit6 busy", r[6], 0);
    wait_done();
    chk("R10 done at end", tx_done, 1);

    // R7 R8 R9 frame formats from the table
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c;
      logic [7:0] d;
      string tag;
      c = VEC[v][15:8];
      d = VEC[v][7:0];
      tag = c[4] ? "R9 nine-bit frame" : (c[2] ? "R8 parity frame" : "R7 plain frame");
      wr(3'd1, c);
      wr(3'd0, d);
      exp_frame(c, d, ef, n);
      rx_frame(n, got, ok);
      chk(tag, {ok, got}, {1'b1, ef});
      wait_done();
    end

    // R11 break
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h5A);
    wr(3'd1, 8'h03);
    lowbad = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b0) lowbad++; end
    chk("R11 line low in break", lowbad, 0);
    rd(3'd6, r); chk("R11 byte held", r, 1);
    wr(3'd1, 8'h01);
    exp_frame(8'h01, 8'h5A, ef, n);
    rx_frame(n, got, ok);
    chk("R11 frame after break", {ok, got}, {1'b1, ef});
    wait_done();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule